// File: doc/BRIEF.md
# Three-Cache Snooping MESI Line Controller

This block models coherence for a single shared memory line held by three private caches that sit on one snooping bus next to a main memory. Each cache keeps a MESI state and its own copy of the data, and the block also keeps the memory value. Processors raise load or store requests against their own cache. The block grants one request per clock, computes the bus transaction the request needs, and updates every cache copy and the memory in that same step. The result registers on the next clock edge, together with a done pulse, the index of the served cache, the line value the requester now holds, and a code naming the bus activity and the agent that drove it.

Stores are write-through with one exception. A store to a line that is Invalid or Shared writes the new value to memory and invalidates every other copy, and the writer ends up Exclusive. A later store to that Exclusive line makes it Modified without any bus activity. A combinational legality monitor watches the held states, the copies and memory, and raises a flag on any global combination that coherence forbids. A preset port loads all states, all copies and memory in one cycle, so that a chosen starting table can be followed by a sequence of operations.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset all three caches are Invalid with data 0, memory is 0, done is low and the illegal flag is low. State encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3, and cache k occupies bits [2k+1:2k] of the state vectors.
- R2: A load by a cache in Invalid, when no other cache holds a valid copy, puts that cache in Exclusive with the memory value and reports bus code 2 (memory to cache) with bus_idx set to the requester.
- R3: A load by a cache in Invalid, when another cache holds Shared or Exclusive and none holds Modified, puts the requester in Shared with the memory value and moves every Exclusive peer to Shared, with bus code 2 and bus_idx set to the requester.
- R4: A load by a cache in Invalid, when another cache holds Modified, writes the owner's value to memory, moves the owner to Shared, and puts the requester in Shared with that value. It reports bus code 1 (cache to memory) with bus_idx set to the owner.
- R5: A store by a cache in Invalid or Shared writes the store data to memory and to the writer's copy, puts the writer in Exclusive and all other caches in Invalid, and reports bus code 1 with bus_idx set to the writer.
- R6: A store by a cache in Exclusive moves it to Modified with the store data, reports bus code 0 (none) and leaves memory unchanged.
- R7: A load by a cache in Modified, Exclusive or Shared, or a store by a cache in Modified, reports bus code 0 and changes no state. Only a store in Modified replaces that cache's data.
- R8: At most one request is served per cycle, and the lowest-indexed requesting cache wins. The clock edge after a request is sampled, done is high for one cycle with done_id set to the served cache and rd_data set to the line value that cache holds after the operation. A cache that loses keeps its request raised until it is served.
- R9: The illegal flag is high whenever a Modified or Exclusive copy coexists with any other valid copy, or exactly one cache is Shared while the other two are Invalid.
- R10: The illegal flag is high whenever a Shared copy's data differs from memory.
- R11: When the preset strobe is high, the next edge loads all states, all copies and memory from the preset inputs. Any request raised in that cycle is ignored: done stays low and no state changes apart from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_en | input | 1 | Preset strobe |
| pre_state | input | 2*NCACHE | Preset MESI states, 2 bits per cache |
| pre_data | input | NCACHE*DW | Preset cache copies |
| pre_mem | input | DW | Preset memory value |
| req_valid | input | NCACHE | Per-cache request raised |
| req_store | input | NCACHE | Per-cache operation: 1 store, 0 load |
| req_wdata | input | NCACHE*DW | Per-cache store data |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | IW | Index of the served cache |
| rd_data | output | DW | Served cache's line value after the operation |
| bus_code | output | 2 | 0 none, 1 cache to memory, 2 memory to cache |
| bus_idx | output | IW | Source cache (code 1) or destination cache (code 2) |
| line_state | output | 2*NCACHE | Current MESI states |
| line_data | output | NCACHE*DW | Current cache copies |
| mem_data | output | DW | Current memory value |
| illegal | output | 1 | Illegal global state flag |

## Verification
The assertions check on every cycle that the lowest requester always wins, that done follows only an accepted request, that a silent operation never touches memory, that after a cache-to-memory transfer memory matches the named cache, that a memory-to-cache transfer leaves the named cache holding the memory value, and that operations starting from a legal table never produce an illegal one. The exact next-state tables for each load and store case, the demotion of Exclusive peers, the illegal-state combinations reachable only by preset, and the effect of a preset colliding with a request can only be shown by the bench's scenarios against its reference model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mstate_t;
  typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_C2M = 2'd1, BUS_M2C = 2'd2} bus_t;

  function automatic logic holds_copy(input logic [1:0] s);
    return s != ST_I;
  endfunction

  function automatic logic owns_line(input logic [1:0] s);
    return (s == ST_M) || (s == ST_E);
  endfunction
endpackage

// File: rtl/mesi_prio_arb.sv
module mesi_prio_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] id
);
  always_comb begin
    any = 1'b0;
    id  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        id  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/mesi_step.sv
module mesi_step
  import mesi_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic [N-1:0][1:0]    st_i,
  input  logic [N-1:0][DW-1:0] dt_i,
  input  logic [DW-1:0]        mem_i,
  input  logic                 go,
  input  logic [IW-1:0]        gid,
  input  logic                 is_store,
  input  logic [DW-1:0]        wdata,
  output logic [N-1:0][1:0]    st_o,
  output logic [N-1:0][DW-1:0] dt_o,
  output logic [DW-1:0]        mem_o,
  output logic [1:0]           code,
  output logic [IW-1:0]        idx,
  output logic [DW-1:0]        rdata
);
  logic          owner_hit;
  logic [IW-1:0] owner;
  logic          peer_valid;

  always_comb begin
    owner_hit  = 1'b0;
    owner      = '0;
    peer_valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (IW'(k) != gid) begin
        if (st_i[k] == ST_M) begin
          owner_hit = 1'b1;
          owner     = IW'(k);
        end
        if (holds_copy(st_i[k])) peer_valid = 1'b1;
      end
    end
  end

  always_comb begin
    st_o  = st_i;
    dt_o  = dt_i;
    mem_o = mem_i;
    code  = BUS_NONE;
    idx   = gid;
    if (go) begin
      if (!is_store) begin
        if (st_i[gid] == ST_I) begin
          if (owner_hit) begin
            mem_o       = dt_i[owner];
            st_o[owner] = ST_S;
            st_o[gid]   = ST_S;
            dt_o[gid]   = dt_i[owner];
            code        = BUS_C2M;
            idx         = owner;
          end else begin
            dt_o[gid] = mem_i;
            code      = BUS_M2C;
            if (peer_valid) begin
              st_o[gid] = ST_S;
              for (int k = 0; k < N; k++)
                if (IW'(k) != gid && st_i[k] == ST_E) st_o[k] = ST_S;
            end else begin
              st_o[gid] = ST_E;
            end
          end
        end
      end else begin
        case (st_i[gid])
          ST_I, ST_S: begin
            mem_o = wdata;
            for (int k = 0; k < N; k++)
              if (IW'(k) != gid) st_o[k] = ST_I;
            st_o[gid] = ST_E;
            dt_o[gid] = wdata;
            code      = BUS_C2M;
          end
          ST_E: begin
            st_o[gid] = ST_M;
            dt_o[gid] = wdata;
          end
          default: dt_o[gid] = wdata;
        endcase
      end
    end
    rdata = dt_o[gid];
  end
endmodule

// File: rtl/mesi_legal.sv
module mesi_legal
  import mesi_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input  logic [N-1:0][1:0]    st,
  input  logic [N-1:0][DW-1:0] dt,
  input  logic [DW-1:0]        mem,
  output logic                 bad
);
  int   n_valid;
  int   n_shared;
  logic any_owner;
  logic stale;

  always_comb begin
    n_valid   = 0;
    n_shared  = 0;
    any_owner = 1'b0;
    stale     = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (holds_copy(st[k])) n_valid++;
      if (st[k] == ST_S) begin
        n_shared++;
        if (dt[k] != mem) stale = 1'b1;
      end
      if (owns_line(st[k])) any_owner = 1'b1;
    end
    bad = (any_owner && n_valid > 1) || (n_shared == 1 && n_valid == 1) || stale;
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NCACHE = 3,
  parameter int DW     = 8,
  localparam int IW    = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pre_en,
  input  logic [2*NCACHE-1:0]    pre_state,
  input  logic [NCACHE*DW-1:0]   pre_data,
  input  logic [DW-1:0]          pre_mem,
  input  logic [NCACHE-1:0]      req_valid,
  input  logic [NCACHE-1:0]      req_store,
  input  logic [NCACHE*DW-1:0]   req_wdata,
  output logic                   done,
  output logic [IW-1:0]          done_id,
  output logic [DW-1:0]          rd_data,
  output logic [1:0]             bus_code,
  output logic [IW-1:0]          bus_idx,
  output logic [2*NCACHE-1:0]    line_state,
  output logic [NCACHE*DW-1:0]   line_data,
  output logic [DW-1:0]          mem_data,
  output logic                   illegal
);
  logic [NCACHE-1:0][1:0]    st_q, st_n;
  logic [NCACHE-1:0][DW-1:0] dt_q, dt_n, wd_arr;
  logic [DW-1:0]             mem_q, mem_n;

  logic                      grant_any;
  logic [IW-1:0]             grant_id;
  logic [1:0]                step_code;
  logic [IW-1:0]             step_idx;
  logic [DW-1:0]             step_rdata;
  logic                      state_bad;

  assign wd_arr = req_wdata;

  mesi_prio_arb #(.N(NCACHE), .IW(IW)) u_arb (
    .req (req_valid),
    .any (grant_any),
    .id  (grant_id)
  );

  mesi_step #(.N(NCACHE), .DW(DW), .IW(IW)) u_step (
    .st_i     (st_q),
    .dt_i     (dt_q),
    .mem_i    (mem_q),
    .go       (grant_any),
    .gid      (grant_id),
    .is_store (req_store[grant_id]),
    .wdata    (wd_arr[grant_id]),
    .st_o     (st_n),
    .dt_o     (dt_n),
    .mem_o    (mem_n),
    .code     (step_code),
    .idx      (step_idx),
    .rdata    (step_rdata)
  );

  mesi_legal #(.N(NCACHE), .DW(DW)) u_legal (
    .st  (st_q),
    .dt  (dt_q),
    .mem (mem_q),
    .bad (state_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= '0;
      dt_q     <= '0;
      mem_q    <= '0;
      done     <= 1'b0;
      done_id  <= '0;
      rd_data  <= '0;
      bus_code <= BUS_NONE;
      bus_idx  <= '0;
    end else if (pre_en) begin
      st_q     <= pre_state;
      dt_q     <= pre_data;
      mem_q    <= pre_mem;
      done     <= 1'b0;
      bus_code <= BUS_NONE;
    end else begin
      st_q     <= st_n;
      dt_q     <= dt_n;
      mem_q    <= mem_n;
      done     <= grant_any;
      done_id  <= grant_id;
      rd_data  <= step_rdata;
      bus_code <= step_code;
      bus_idx  <= step_idx;
    end
  end

  assign line_state = st_q;
  assign line_data  = dt_q;
  assign mem_data   = mem_q;
  assign illegal    = state_bad;
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
  parameter int NCACHE = 3,
  parameter int DW     = 8,
  parameter int IW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pre_en,
  input logic [NCACHE-1:0]    req_valid,
  input logic                 done,
  input logic [IW-1:0]        done_id,
  input logic [1:0]           bus_code,
  input logic [IW-1:0]        bus_idx,
  input logic [NCACHE*DW-1:0] line_data,
  input logic [DW-1:0]        mem_data,
  input logic                 illegal
);
  // R8: lowest index wins
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_valid[0])) |-> (done_id == '0));

  // R8, R11: done only after an accepted request
  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(|req_valid) && !$past(pre_en)));

  // R6, R7: silent operations leave memory alone
  p_silent_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_code == 2'd0) |-> (mem_data == $past(mem_data)));

  // R4, R5: cache-to-memory leaves memory equal to the source copy
  p_c2m_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_code == 2'd1) |-> (mem_data == line_data[bus_idx*DW +: DW]));

  // R2, R3: memory-to-cache leaves destination equal to memory
  p_m2c_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bus_code == 2'd2) |-> (line_data[bus_idx*DW +: DW] == mem_data));

  // R9: operations never turn a legal table illegal
  p_legal_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(illegal) && !$past(pre_en)) |-> !illegal);
endmodule

bind mesi_line_ctrl mesi_line_chk #(.NCACHE(NCACHE), .DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pre_en    (pre_en),
  .req_valid (req_valid),
  .done      (done),
  .done_id   (done_id),
  .bus_code  (bus_code),
  .bus_idx   (bus_idx),
  .line_data (line_data),
  .mem_data  (mem_data),
  .illegal   (illegal)
);

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pre_en;
  logic [5:0]    pre_state;
  logic [23:0]   pre_data;
  logic [7:0]    pre_mem;
  logic [2:0]    req_valid;
  logic [2:0]    req_store;
  logic [23:0]   req_wdata;
  logic          done;
  logic [1:0]    done_id;
  logic [7:0]    rd_data;
  logic [1:0]    bus_code;
  logic [1:0]    bus_idx;
  logic [5:0]    line_state;
  logic [23:0]   line_data;
  logic [7:0]    mem_data;
  logic          illegal;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model: 0=I 1=S 2=E 3=M
  int mst[3];
  int mdt[3];
  int mmem;
  int ecode, eidx, erd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.NCACHE(N), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_state(pre_state),
    .pre_data(pre_data), .pre_mem(pre_mem), .req_valid(req_valid),
    .req_store(req_store), .req_wdata(req_wdata), .done(done),
    .done_id(done_id), .rd_data(rd_data), .bus_code(bus_code),
    .bus_idx(bus_idx), .line_state(line_state), .line_data(line_data),
    .mem_data(mem_data), .illegal(illegal)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_illegal();
    int nv = 0, ns = 0;
    bit own = 0, stale = 0;
    for (int k = 0; k < 3; k++) begin
      if (mst[k] != 0) nv++;
      if (mst[k] >= 2) own = 1;
      if (mst[k] == 1) begin
        ns++;
        if (mdt[k] != mmem) stale = 1;
      end
    end
    return ((own && nv > 1) || (ns == 1 && nv == 1) || stale) ? 1 : 0;
  endfunction

  task automatic cmp_table(string req);
    for (int k = 0; k < 3; k++) begin
      chk({req, " state"}, int'(line_state[2*k +: 2]), mst[k]);
      chk({req, " data"}, int'(line_data[8*k +: 8]), mdt[k]);
    end
    chk({req, " mem"}, int'(mem_data), mmem);
    chk({req, " illegal"}, int'(illegal), ref_illegal());
  endtask

  task automatic model_op(int c, bit st, int wd);
    ecode = 0; eidx = c;
    if (!st) begin
      if (mst[c] == 0) begin
        int own = -1;
        bit peer = 0;
        for (int k = 0; k < 3; k++) if (k != c) begin
          if (mst[k] == 3) own = k;
          if (mst[k] != 0) peer = 1;
        end
        if (own >= 0) begin
          mmem = mdt[own]; mst[own] = 1; mst[c] = 1; mdt[c] = mdt[own];
          ecode = 1; eidx = own;
        end else begin
          mdt[c] = mmem; ecode = 2;
          if (peer) begin
            mst[c] = 1;
            for (int k = 0; k < 3; k++) if (k != c && mst[k] == 2) mst[k] = 1;
          end else mst[c] = 2;
        end
      end
    end else begin
      if (mst[c] <= 1) begin
        mmem = wd;
        for (int k = 0; k < 3; k++) if (k != c) mst[k] = 0;
        mst[c] = 2; mdt[c] = wd; ecode = 1;
      end else begin
        mst[c] = 3; mdt[c] = wd;
      end
    end
    erd = mdt[c];
  endtask

  task automatic cmp_done(string req, int c);
    chk({req, " done"}, int'(done), 1);
    chk({req, " done_id"}, int'(done_id), c);
    chk({req, " rd_data"}, int'(rd_data), erd);
    chk({req, " bus_code"}, int'(bus_code), ecode);
    if (ecode != 0) chk({req, " bus_idx"}, int'(bus_idx), eidx);
    cmp_table(req);
  endtask

  task automatic op(string req, int c, bit st, int wd);
    req_valid[c] = 1'b1;
    req_store[c] = st;
    req_wdata[8*c +: 8] = 8'(wd);
    @(negedge clk);
    model_op(c, st, wd);
    cmp_done(req, c);
    req_valid = '0;
  endtask

  task automatic preset(int s0, int d0, int s1, int d1, int s2, int d2, int m);
    pre_en = 1'b1;
    pre_state = {2'(s2), 2'(s1), 2'(s0)};
    pre_data  = {8'(d2), 8'(d1), 8'(d0)};
    pre_mem   = 8'(m);
    @(negedge clk);
    pre_en = 1'b0;
    mst[0] = s0; mst[1] = s1; mst[2] = s2;
    mdt[0] = d0; mdt[1] = d1; mdt[2] = d2; mmem = m;
    chk("R11 done after preset", int'(done), 0);
    cmp_table("R11 preset");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pre_en = 1'b0; pre_state = '0; pre_data = '0; pre_mem = '0;
    req_valid = '0; req_store = '0; req_wdata = '0;
    for (int k = 0; k < 3; k++) begin mst[k] = 0; mdt[k] = 0; end
    mmem = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    cmp_table("R1 reset");

    // R2: load with all Invalid
    op("R2 load miss alone", 0, 1'b0, 0);
    // R7: load hit in Exclusive
    op("R7 load hit E", 0, 1'b0, 0);
    // R3: load with Exclusive peer
    op("R3 load miss E peer", 2, 1'b0, 0);
    // R7: load hit in Shared
    op("R7 load hit S", 2, 1'b0, 0);

    // R3 / R5 from a starting table E2 I3 I9 mem2
    preset(2, 2, 0, 3, 0, 9, 2);
    op("R3 load miss peer E", 1, 1'b0, 0);
    op("R5 store from S", 1, 1'b1, 3);

    // R4: owner in Modified
    preset(3, 1, 0, 2, 0, 4, 3);
    op("R4 load miss M owner", 1, 1'b0, 0);

    // R5, R6, R7 on cache 2
    preset(0, 6, 1, 0, 1, 0, 0);
    op("R5 store from S peers", 2, 1'b1, 4);
    op("R6 store E to M", 2, 1'b1, 6);
    op("R7 store hit M", 2, 1'b1, 7);
    op("R4 load miss M owner c0", 0, 1'b0, 0);
    op("R5 store from I", 1, 1'b1, 8'hA5);

    // R8: cache 1 and 2 together, 1 wins, 2 holds request
    req_valid = 3'b110; req_store = 3'b000;
    @(negedge clk);
    model_op(1, 1'b0, 0);
    cmp_done("R8 priority first", 1);
    req_valid = 3'b100;
    @(negedge clk);
    model_op(2, 1'b0, 0);
    cmp_done("R8 priority second", 2);
    req_valid = '0;
    @(negedge clk);
    chk("R8 done single pulse", int'(done), 0);

    // R9: illegal combinations
    preset(3, 3, 0, 2, 2, 3, 3);
    chk("R9 M with E", int'(illegal), 1);
    preset(0, 2, 0, 4, 1, 2, 2);
    chk("R9 lone S", int'(illegal), 1);
    preset(3, 6, 0, 6, 0, 4, 4);
    chk("R9 lone M legal", int'(illegal), 0);
    // R10: stale Shared copy
    preset(1, 5, 0, 0, 1, 3, 5);
    chk("R10 stale S", int'(illegal), 1);

    // R11: preset beats a request in the same cycle
    req_valid = 3'b001; req_store = 3'b001; req_wdata = 24'h000077;
    preset(0, 1, 0, 2, 0, 3, 9);
    req_valid = '0;
    chk("R11 ignored req data c0", int'(line_data[7:0]), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule